// File: doc/BRIEF.md
# External Bus Release Controller

This block lets an outside bus master borrow the external bus of the chip. The outside master pulls an active-low request line. After synchronisation, and only at a bus cycle boundary, the block pulls its active-low acknowledge line. In the same clock it drops the output enable for the address, data and control pads, so those pads float. While the bus is lent out, the on-chip bus master keeps running. Accesses that stay on the internal bus are granted in the cycle they are asked for. Accesses that need the external bus are stalled until the bus comes back.

Two configuration bits are loaded through a one-cycle write strobe, and both are cleared by reset. One bit permits lending the bus at all. Lending is also possible only while the chip runs in external expansion mode. The other bit lets the block pull a separate active-low line while an external access is stalled, which asks the outside master to hand the bus back.

When the outside request goes away, the acknowledge line rises first. The pads are driven again one clock later, and a stalled external access is granted from that clock on. A lending request that becomes visible in the same cycle as an external access from the on-chip master takes priority over that access.

Top module: `busrel_ctrl`

## Requirements
- R1: After reset `ext_ack_n`=1, `req_back_n`=1, `bus_oe`=1 and both configuration bits are 0, so a low `ext_req_n` is ignored until software sets them.
- R2: The bus is lent only when `exp_mode`=1 and the release-enable bit (`cfg_wdata[0]`) is 1; otherwise a low `ext_req_n` leaves `ext_ack_n`=1 and `bus_oe`=1.
- R3: With lending allowed and no cycle in progress, `ext_ack_n` falls on the third rising edge after `ext_req_n` goes low (two synchroniser flops plus the state register), and `bus_oe` falls on that same edge.
- R4: `ext_ack_n` does not fall while `cycle_busy`=1; it falls on the first rising edge at which the synchronised request is seen with `cycle_busy`=0.
- R5: A request with `im_ext`=0 gets `im_grant`=1 and `im_stall`=0 in the same cycle, whatever the bus state.
- R6: A request with `im_ext`=1 gets `im_grant`=0 and `im_stall`=1 whenever `bus_oe`=0.
- R7: `req_back_n` is 0 exactly when the bus is lent (`ext_ack_n`=0), the request-back-enable bit (`cfg_wdata[1]`) is 1, and `im_req`=1 with `im_ext`=1; it is 1 in every other case.
- R8: After `ext_req_n` returns high, `ext_ack_n` rises on the third rising edge and `bus_oe` rises one edge later; a stalled external access is granted from the cycle in which `bus_oe` is 1.
- R9: In a cycle where the synchronised request would start a lend, an external access is stalled rather than granted.
- R10: `cfg_wr`=1 loads `cfg_wdata[0]` into release-enable and `cfg_wdata[1]` into request-back-enable on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_mode | input | 1 | Chip runs in external expansion mode |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 0 release-enable, bit 1 request-back-enable |
| ext_req_n | input | 1 | Outside master's bus request, active low, asynchronous |
| ext_ack_n | output | 1 | Bus lent acknowledge, active low |
| req_back_n | output | 1 | Ask outside master to return the bus, active low |
| bus_oe | output | 1 | 1 drives address, data and control pads; 0 floats them |
| cycle_busy | input | 1 | External bus cycle in progress (from sequencer) |
| im_req | input | 1 | On-chip master access request |
| im_ext | input | 1 | The requested access needs the external bus |
| im_grant | output | 1 | Access may proceed this cycle |
| im_stall | output | 1 | Access must wait |

## Verification
The grant path is tried with a table that crosses internal versus external accesses, idle cycles, and both settings of the request-back bit, once with the bus owned and once with it lent. This separates a correct stall from a blanket stall and shows that the request-back line reacts only in the lent state. Directed sequences count edges on entry and exit to pin down the synchroniser depth and the extra clock before the pads are driven again. They hold `cycle_busy` to show that lending waits for a boundary, and they present an external access in the very cycle the request becomes visible to show that lending wins.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

   typedef enum logic [1:0] {
      BR_OWN = 2'd0,   // bus driven by this chip
      BR_LENT = 2'd1,  // bus handed to outside master
      BR_BACK = 2'd2   // acknowledge withdrawn, pads still floating
   } br_state_e;

   typedef struct packed {
      logic back_en;
      logic lend_en;
   } br_cfg_t;

   localparam int BR_CFG_W = $bits(br_cfg_t);

endpackage

// File: rtl/busrel_sync.sv
module busrel_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("busrel_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/busrel_fsm.sv
module busrel_fsm
   import busrel_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_seen,
   input  logic      allow,
   input  logic      cycle_busy,
   output br_state_e state,
   output logic      lend_go,
   output logic      ack_n,
   output logic      oe
);

   br_state_e nxt;

   assign lend_go = (state == BR_OWN) && allow && req_seen && !cycle_busy;

   always_comb begin
      nxt = state;
      unique case (state)
         BR_OWN:  if (lend_go)   nxt = BR_LENT;
         BR_LENT: if (!req_seen) nxt = BR_BACK;
         BR_BACK: nxt = BR_OWN;
         default: nxt = BR_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= BR_OWN;
      else        state <= nxt;
   end

   assign ack_n = (state != BR_LENT);
   assign oe    = (state == BR_OWN);

   // R4: acknowledge only falls after a cycle with no bus cycle running
   a_r4_ack_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n) |-> !$past(cycle_busy));

   // R2: no lend without permission
   a_r2_lend_needs_allow: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BR_OWN && !allow) |=> (state != BR_LENT));

   // R8: pads return only one clock after acknowledge rose
   a_r8_oe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> ($past(ack_n) && $past(state) == BR_BACK));

endmodule

// File: rtl/busrel_arb.sv
module busrel_arb
   import busrel_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  br_state_e state,
   input  logic      lend_go,
   input  logic      back_en,
   input  logic      im_req,
   input  logic      im_ext,
   output logic      im_grant,
   output logic      im_stall,
   output logic      req_back_n
);

   logic ext_ok;
   logic ext_pending;

   assign ext_ok      = (state == BR_OWN) && !lend_go;
   assign ext_pending = im_req && im_ext;
   assign im_grant    = im_req && (!im_ext || ext_ok);
   assign im_stall    = ext_pending && !ext_ok;
   assign req_back_n  = !(ext_pending && back_en && (state == BR_LENT));

   // R5: internal-only accesses always pass
   a_r5_internal_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (im_req && !im_ext) |-> (im_grant && !im_stall));

   // R6: no external grant unless bus is owned
   a_r6_no_ext_grant_lent: assert property (@(posedge clk) disable iff (!rst_n)
      (state != BR_OWN) |-> !(im_grant && im_ext));

   // R7: request-back line silent when disabled
   a_r7_back_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !back_en |-> req_back_n);

endmodule

// File: rtl/busrel_ctrl.sv
module busrel_ctrl
   import busrel_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       exp_mode,
   input  logic       cfg_wr,
   input  logic [1:0] cfg_wdata,
   input  logic       ext_req_n,
   output logic       ext_ack_n,
   output logic       req_back_n,
   output logic       bus_oe,
   input  logic       cycle_busy,
   input  logic       im_req,
   input  logic       im_ext,
   output logic       im_grant,
   output logic       im_stall
);

   if (BR_CFG_W != 2) begin : g_bad_cfg
      $error("configuration word width mismatch");
   end

   br_cfg_t   cfg_q;
   br_state_e state;
   logic      req_n_sync;
   logic      lend_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= br_cfg_t'(cfg_wdata);
   end

   busrel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_req_n),
      .q     (req_n_sync)
   );

   busrel_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_seen   (!req_n_sync),
      .allow      (exp_mode && cfg_q.lend_en),
      .cycle_busy (cycle_busy),
      .state      (state),
      .lend_go    (lend_go),
      .ack_n      (ext_ack_n),
      .oe         (bus_oe)
   );

   busrel_arb u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .lend_go    (lend_go),
      .back_en    (cfg_q.back_en),
      .im_req     (im_req),
      .im_ext     (im_ext),
      .im_grant   (im_grant),
      .im_stall   (im_stall),
      .req_back_n (req_back_n)
   );

   // R3: acknowledged bus never has pads driven
   a_r3_ack_implies_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_ack_n |-> !bus_oe);

   // R7: request-back only while bus is lent
   a_r7_back_only_lent: assert property (@(posedge clk) disable iff (!rst_n)
      !req_back_n |-> !ext_ack_n);

endmodule

// File: tb/busrel_ctrl_test.sv
module busrel_ctrl_test;

   localparam int PERIOD = 10;
   localparam int NVEC = 9;
   // {phase, im_req, im_ext, back_en, exp_grant, exp_stall, exp_req_back_n}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b0_100_101,  // R5 owned, internal
      7'b0_110_101,  // R6 owned, external granted
      7'b0_011_001,  // R7 idle
      7'b0_111_101,  // R7 owned: no request-back
      7'b1_100_101,  // R5 lent, internal still passes
      7'b1_110_011,  // R6 lent, external stalls, back disabled
      7'b1_111_010,  // R7 lent, back enabled, pending -> low
      7'b1_011_001,  // R7 lent, nothing pending
      7'b1_101_101   // R5 lent, internal with back enabled
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic exp_mode = 1'b0, cfg_wr = 1'b0, ext_req_n = 1'b1;
   logic [1:0] cfg_wdata = 2'b00;
   logic cycle_busy = 1'b0, im_req = 1'b0, im_ext = 1'b0;
   logic ext_ack_n, req_back_n, bus_oe, im_grant, im_stall;
   int n_chk = 0, n_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   busrel_ctrl uut (
      .clk(clk), .rst_n(rst_n), .exp_mode(exp_mode), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .ext_req_n(ext_req_n), .ext_ack_n(ext_ack_n),
      .req_back_n(req_back_n), .bus_oe(bus_oe), .cycle_busy(cycle_busy),
      .im_req(im_req), .im_ext(im_ext), .im_grant(im_grant), .im_stall(im_stall)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_cfg(input logic [1:0] v);
      cfg_wdata = v; cfg_wr = 1'b1;
      tick(1);
      cfg_wr = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic phase;
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk("R1", "ack_n", ext_ack_n, 1'b1);
      chk("R1", "req_back_n", req_back_n, 1'b1);
      chk("R1", "bus_oe", bus_oe, 1'b1);

      // R1/R2: config bits clear after reset, request ignored
      exp_mode = 1'b1; ext_req_n = 1'b0; im_req = 1'b1; im_ext = 1'b1;
      tick(5);
      chk("R1", "ack_n ignored", ext_ack_n, 1'b1);
      chk("R2", "ext grant while ignored", im_grant, 1'b1);

      // R2: expansion mode off blocks lending
      exp_mode = 1'b0;
      write_cfg(2'b01);
      tick(5);
      chk("R2", "ack_n no exp_mode", ext_ack_n, 1'b1);
      chk("R2", "bus_oe no exp_mode", bus_oe, 1'b1);
      ext_req_n = 1'b1; exp_mode = 1'b1; im_req = 1'b0;
      tick(4);

      // vector table
      phase = 1'b0;
      for (int k = 0; k < NVEC; k++) begin
         if (VEC[k][6] != phase) begin
            im_req = 1'b1; im_ext = 1'b1; ext_req_n = 1'b0;
            tick(2);
            chk("R3", "ack_n before third edge", ext_ack_n, 1'b1);
            chk("R9", "stall on lend cycle", im_stall, 1'b1);
            chk("R9", "no grant on lend cycle", im_grant, 1'b0);
            tick(1);
            chk("R3", "ack_n third edge", ext_ack_n, 1'b0);
            chk("R3", "bus_oe third edge", bus_oe, 1'b0);
            phase = 1'b1;
         end
         write_cfg({VEC[k][3], 1'b1});
         im_req = VEC[k][5]; im_ext = VEC[k][4];
         #1;
         chk("R10/R5/R6", $sformatf("grant v%0d", k), im_grant, VEC[k][2]);
         chk("R6", $sformatf("stall v%0d", k), im_stall, VEC[k][1]);
         chk("R7", $sformatf("req_back_n v%0d", k), req_back_n, VEC[k][0]);
      end

      // R8: exit with a stalled external access
      write_cfg(2'b11);
      im_req = 1'b1; im_ext = 1'b1; ext_req_n = 1'b1;
      tick(2);
      chk("R8", "ack_n still low", ext_ack_n, 1'b0);
      chk("R7", "req_back_n low while pending", req_back_n, 1'b0);
      tick(1);
      chk("R8", "ack_n rose", ext_ack_n, 1'b1);
      chk("R8", "bus_oe still off", bus_oe, 1'b0);
      chk("R6", "stall during return", im_stall, 1'b1);
      chk("R7", "req_back_n released", req_back_n, 1'b1);
      tick(1);
      chk("R8", "bus_oe back", bus_oe, 1'b1);
      chk("R8", "deferred grant", im_grant, 1'b1);

      // R4: boundary hold
      im_req = 1'b0; cycle_busy = 1'b1; ext_req_n = 1'b0;
      tick(5);
      chk("R4", "ack_n held during cycle", ext_ack_n, 1'b1);
      chk("R4", "bus_oe held during cycle", bus_oe, 1'b1);
      cycle_busy = 1'b0;
      tick(1);
      chk("R4", "ack_n at boundary", ext_ack_n, 1'b0);
      ext_req_n = 1'b1;
      tick(4);
      chk("R8", "bus_oe after second exit", bus_oe, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule